// File: doc/BRIEF.md
# Byte-Level SPI Serial Memory Slave

This block plays the memory side of a small SPI serial memory. A host SPI controller hands it one byte per transfer on a byte-wide strobe interface, and one clock later the block returns the response byte for that transfer. Bit-level shifting, erase commands and programming delays are handled elsewhere or not modelled. The storage is an internal array that maps onto block RAM.

Each chip-select window carries one command. The first byte is the opcode. The next three bytes are a 24-bit address, most significant byte first. Every byte after that is a data byte, and the command acts on it. Five commands are understood: write-enable, write-disable, status read, memory read and memory write. Only the low bits of the address that fit the array depth are used, so the address wraps. Dropping chip select at any point ends the command, and the next byte is taken as a new opcode.

Top module: `spi_mem_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, resp_valid is 0. After reset the write-enable status bit is clear, and the first accepted byte is treated as an opcode.
- R2: A byte is accepted when byte_valid and cs_active are both high on a clock edge. Each accepted byte produces resp_valid high for exactly one cycle, on the following cycle, with resp_byte. A byte presented while cs_active is low produces no response.
- R3: The first accepted byte after cs_active rises is the opcode, and the address register is cleared to zero at that point. The next three bytes are shifted into the low end of the address, so the most significant byte arrives first. The response to the opcode and to all three address bytes is 0x00.
- R4: Opcode 0x06 sets status bit 1 (write enable) on each data byte. Its responses are 0x00.
- R5: Opcode 0x04 clears status bit 1 on each data byte. Its responses are 0x00.
- R6: Under opcode 0x05, each data byte returns the status register as the response. Bit 1 is write enable and all other bits are 0.
- R7: Under opcode 0x02 with write enable set, each data byte is stored at the current address and the address then increments. Write data bytes respond with 0x00.
- R8: Under opcode 0x02 with write enable clear, the memory is left unchanged, but the address still increments.
- R9: Under opcode 0x03, each data byte returns the memory byte at the current address and the address then increments.
- R10: Only the low log2(DEPTH) address bits select a location. Higher address bits are ignored, and incrementing past the last location wraps to location 0.
- R11: Dropping cs_active clears the command state at any phase. The next accepted byte is a new opcode. The write-enable bit keeps its value.
- R12: An opcode other than 0x02 through 0x06 returns 0x00 for every byte and changes neither the memory nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip select, high while a command is in progress |
| byte_valid | input | 1 | Strobe: a transfer byte is present on byte_in |
| byte_in | input | 8 | Byte sent by the host |
| resp_valid | output | 1 | Response byte valid, one cycle after an accepted byte |
| resp_byte | output | 8 | Byte returned to the host for the accepted transfer |

## Verification
A phase counter that slips shows up at the ports within one command. A data byte is then taken as an address byte, which moves the read data returned by the next memory read, or a status read comes back as 0x00 where the status was expected. A wrong address register, or a missed increment, shows on the next read as data returned from a neighbouring location, including across the wrap point. A write-enable bit that is stuck or misdecoded shows only after a write followed by a read of the same location, or after a status read. The bench therefore pairs every status change with a read-back.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDIS = 8'h04;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam int ADDR_BYTES = 3;
  localparam int ADDR_BITS  = 8 * ADDR_BYTES;
endpackage

// File: rtl/spi_mem_status.sv
module spi_mem_status #(
  parameter int WE_BIT = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_we,
  input  logic       clr_we,
  output logic       we_bit,
  output logic [7:0] status
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b0;
    end else if (set_we) begin
      we_q <= 1'b1;
    end else if (clr_we) begin
      we_q <= 1'b0;
    end
  end

  always_comb begin
    status         = 8'h00;
    status[WE_BIT] = we_q;
  end

  assign we_bit = we_q;
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wr_data;
    end
    rd_data <= mem[addr];
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_active,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       resp_valid,
  output logic [7:0] resp_byte
);
  phase_e                phase_q;
  logic [1:0]            acnt_q;
  logic [7:0]            opcode_q;
  logic [ADDR_BITS-1:0]  addr_q;
  logic                  resp_valid_q;
  logic                  resp_ram_q;
  logic [7:0]            resp_misc_q;
  logic [7:0]            ram_q;
  logic [7:0]            status;
  logic                  we_bit;

  logic fire, data_fire;
  logic op_rd, op_wr, op_we, op_wd, op_st;

  assign fire      = cs_active & byte_valid;
  assign data_fire = fire && (phase_q == PH_DATA);
  assign op_rd     = (opcode_q == OP_READ);
  assign op_wr     = (opcode_q == OP_WRITE);
  assign op_we     = (opcode_q == OP_WREN);
  assign op_wd     = (opcode_q == OP_WRDIS);
  assign op_st     = (opcode_q == OP_STAT);

  // command sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_OPC;
      acnt_q   <= 2'd0;
      opcode_q <= 8'h00;
      addr_q   <= '0;
    end else if (!cs_active) begin
      phase_q <= PH_OPC;
      acnt_q  <= 2'd0;
    end else if (byte_valid) begin
      unique case (phase_q)
        PH_OPC: begin
          opcode_q <= byte_in;
          addr_q   <= '0;
          acnt_q   <= 2'd0;
          phase_q  <= PH_ADDR;
        end
        PH_ADDR: begin
          addr_q <= {addr_q[ADDR_BITS-9:0], byte_in};
          acnt_q <= acnt_q + 2'd1;
          if (acnt_q == 2'(ADDR_BYTES - 1)) begin
            phase_q <= PH_DATA;
          end
        end
        PH_DATA: begin
          if (op_rd || op_wr) begin
            addr_q <= addr_q + 1'b1;
          end
        end
        default: phase_q <= PH_OPC;
      endcase
    end
  end

  // response registers
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid_q <= 1'b0;
      resp_ram_q   <= 1'b0;
      resp_misc_q  <= 8'h00;
    end else begin
      resp_valid_q <= fire;
      resp_ram_q   <= data_fire && op_rd;
      resp_misc_q  <= (data_fire && op_st) ? status : 8'h00;
    end
  end

  spi_mem_status #(.WE_BIT(1)) u_status (
    .clk    (clk),
    .rst    (rst),
    .set_we (data_fire && op_we),
    .clr_we (data_fire && op_wd),
    .we_bit (we_bit),
    .status (status)
  );

  spi_mem_ram #(.DW(8), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (data_fire && op_wr && we_bit),
    .addr    (addr_q[AW-1:0]),
    .wr_data (byte_in),
    .rd_data (ram_q)
  );

  assign resp_valid = resp_valid_q;
  assign resp_byte  = resp_ram_q ? ram_q : resp_misc_q;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
  import spi_mem_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_active,
  input logic                 byte_valid,
  input logic                 resp_valid,
  input logic [7:0]           resp_byte,
  input phase_e               phase_q,
  input logic [7:0]           opcode_q,
  input logic [ADDR_BITS-1:0] addr_q,
  input logic                 we_bit
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !resp_valid); // R1

  AST_RESP_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    (cs_active && byte_valid) |=> resp_valid); // R2

  AST_NO_RESP_WITHOUT_CS: assert property (@(posedge clk) disable iff (rst)
    !(cs_active && byte_valid) |=> !resp_valid); // R2

  AST_HEADER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cs_active && byte_valid && phase_q != PH_DATA) |=> (resp_byte == 8'h00)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_active && !byte_valid) |=> $stable(addr_q)); // R3

  AST_WE_SET_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(we_bit) |-> $past(opcode_q == OP_WREN && phase_q == PH_DATA)); // R4

  AST_WE_CLR_SRC: assert property (@(posedge clk) disable iff (rst)
    $fell(we_bit) |-> $past(opcode_q == OP_WRDIS && phase_q == PH_DATA)); // R5

  AST_CS_RESTART: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> (phase_q == PH_OPC)); // R11
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_active  (cs_active),
  .byte_valid (byte_valid),
  .resp_valid (resp_valid),
  .resp_byte  (resp_byte),
  .phase_q    (phase_q),
  .opcode_q   (opcode_q),
  .addr_q     (addr_q),
  .we_bit     (we_bit)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_active = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       resp_valid;
  logic [7:0] resp_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  spi_mem_slave #(.DEPTH(256)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .cs_active  (cs_active),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .resp_valid (resp_valid),
    .resp_byte  (resp_byte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", int'(resp_byte), 0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(resp_byte == e, t, int'(resp_byte), int'(e));
      end
    end
  end

  task automatic send(input logic [7:0] b, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    byte_valid = 1'b1;
    byte_in    = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op, input logic [23:0] a, input string tag);
    cs_active = 1'b1;
    send(op, 8'h00, {tag, " R3 opcode resp"});
    send(a[23:16], 8'h00, {tag, " R3 addr resp"});
    send(a[15:8],  8'h00, {tag, " R3 addr resp"});
    send(a[7:0],   8'h00, {tag, " R3 addr resp"});
  endtask

  task automatic release_cs();
    cs_active = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_status(input logic [7:0] exp, input string tag);
    cmd(8'h05, 24'h0, tag);
    send(8'h00, exp, tag);
    send(8'h00, exp, tag);
    release_cs();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0, "R1 resp_valid in reset", int'(resp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(resp_valid == 1'b0, "R1 resp_valid after reset", int'(resp_valid), 0);

    rd_status(8'h00, "R1 status after reset");

    // R2: byte with cs low gives no response
    byte_valid = 1'b1; byte_in = 8'h06;
    @(negedge clk);
    byte_valid = 1'b0;
    check(resp_valid == 1'b0, "R2 no resp with cs low", int'(resp_valid), 0);
    @(negedge clk);

    // R4 set write enable, R6 read it
    cmd(8'h06, 24'h0, "R4");
    send(8'h00, 8'h00, "R4 wren data resp");
    release_cs();
    rd_status(8'h02, "R6 status with WE set");

    // R7 write several bytes, R9 read back
    cmd(8'h02, 24'h000040, "R7");
    send(8'hA1, 8'h00, "R7 wr resp");
    send(8'hB2, 8'h00, "R7 wr resp");
    send(8'hC3, 8'h00, "R7 wr resp");
    release_cs();
    cmd(8'h03, 24'h000040, "R9");
    send(8'h00, 8'hA1, "R9 read byte0");
    send(8'h00, 8'hB2, "R9 read byte1");
    send(8'h00, 8'hC3, "R9 read byte2");
    release_cs();
    cmd(8'h03, 24'h000041, "R9");
    send(8'h00, 8'hB2, "R9 read offset start");
    release_cs();

    // R10 wrap and high address bits ignored
    cmd(8'h02, 24'h0001FF, "R10");
    send(8'h11, 8'h00, "R10 wr last");
    send(8'h22, 8'h00, "R10 wr wrapped");
    release_cs();
    cmd(8'h03, 24'h1234FF, "R10");
    send(8'h00, 8'h11, "R10 read last high bits ignored");
    send(8'h00, 8'h22, "R10 read wrapped to 0");
    release_cs();

    // R5 clear write enable, R8 write blocked but address increments
    cmd(8'h04, 24'h0, "R5");
    send(8'h00, 8'h00, "R5 wrdi data resp");
    release_cs();
    rd_status(8'h00, "R5 status after WRDI");
    cmd(8'h02, 24'h000040, "R8");
    send(8'h55, 8'h00, "R8 blocked wr resp");
    send(8'h66, 8'h00, "R8 blocked wr resp");
    release_cs();
    cmd(8'h03, 24'h000040, "R8");
    send(8'h00, 8'hA1, "R8 memory unchanged 0x40");
    send(8'h00, 8'hB2, "R8 memory unchanged 0x41");
    release_cs();
    cmd(8'h06, 24'h0, "R8"); send(8'h00, 8'h00, "R8 wren"); release_cs();
    cmd(8'h04, 24'h0, "R8");
    send(8'h00, 8'h00, "R8 wrdi");
    release_cs();

    // R11 mid-command release; WE keeps value across cs
    cmd(8'h06, 24'h0, "R11"); send(8'h00, 8'h00, "R11 wren"); release_cs();
    cmd(8'h03, 24'h000040, "R11");
    send(8'h00, 8'hA1, "R11 read before drop");
    release_cs();
    cs_active = 1'b1;
    send(8'h05, 8'h00, "R11 new opcode resp");
    send(8'h00, 8'h00, "R11 addr resp");
    release_cs();
    rd_status(8'h02, "R11 WE kept across cs");

    // R12 unknown opcode
    cmd(8'h9F, 24'h000040, "R12");
    send(8'h77, 8'h00, "R12 data resp zero");
    send(8'h00, 8'h00, "R12 data resp zero");
    release_cs();
    rd_status(8'h02, "R12 status unchanged");
    cmd(8'h03, 24'h000040, "R12");
    send(8'h00, 8'hA1, "R12 memory unchanged");
    release_cs();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 missing responses", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule